// File: doc/BRIEF.md
# Multichannel Audio Sample Refill Engine

This block keeps eight small sample queues topped up from a 32-bit word-wide memory, so that a downstream filter and mixer always has 16-bit audio samples ready, one queue per channel. A control processor starts a channel by giving it a start word address and a loop length in words. After that the engine fetches on its own. It picks a channel that has space, issues one word read, splits the returned word into two samples and appends them to that channel's queue.

Writing a new start address to a running channel retargets it. The channel's queue is emptied, fetching restarts at the new address, and a read that was already under way for the old stream is dropped when its data comes back. When a channel's read position reaches the end of its window it loops back to the start and raises a sticky wrap flag. The flag stays set until the channel is configured again.

Top module: `audio_refill`

## Requirements
- R1: Each channel has a queue of 16 samples. `smp_valid[c]` is high while queue c is not empty, and `smp_data[16c+15:16c]` shows its oldest sample. A `smp_pop[c]` pulse removes that sample at the clock edge. A pop on an empty queue is ignored.
- R2: After reset no channel is active. `mem_req` stays low, and every `smp_valid` and `wrapped` bit is low until a channel has been configured.
- R3: A configuration write (`cfg_we`, with `cfg_ch`, `cfg_base` and `cfg_len`) activates the channel. Its word offset is set to 0. Each acknowledged read for the channel uses address base+offset and then advances the offset by one.
- R4: When offset+1 is at least the length, the offset returns to 0 and `wrapped[c]` is set. A length of 0 behaves like a length of 1. A configuration write clears `wrapped[c]`.
- R5: Each returned word delivers bits 15:0 as the earlier sample and bits 31:16 as the next one.
- R6: A channel is granted a read only while its queue holds 14 or fewer samples, so a queue never holds more than 16 samples.
- R7: Among channels that are active and have room, grants go round-robin. The search starts at the channel after the last one granted, and the search pointer is channel 0 after reset.
- R8: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. Only one read is outstanding at a time, and no new request appears until `mem_rvalid` has returned its data.
- R9: A configuration write empties the channel's queue at that edge and restarts its stream at the new base.
- R10: Read data is discarded if its channel received a configuration write at any edge from the one that issued the request up to and including the edge that returns the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel being configured |
| cfg_base | input | 16 | Start word address of the stream |
| cfg_len | input | 16 | Loop length in words |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 16 | Word address of the request |
| mem_ack | input | 1 | Memory accepted the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| smp_pop | input | 8 | Per-channel sample consume strobe |
| smp_valid | output | 8 | Per-channel queue not empty |
| smp_data | output | 128 | Oldest sample per channel, 16 bits each |
| wrapped | output | 8 | Sticky per-channel loop flag |

## Verification
The assertions take the following for granted about the memory side:
- `mem_ack` comes only while `mem_req` is high.
- `mem_rvalid` pulses exactly once per accepted request, no earlier than the cycle after the acknowledge.

The bench acts as that memory. It counts a random delay of zero to three cycles before each acknowledge and again before each data return, and it never produces either pulse outside those windows. Configuration writes land freely, including on the request, acknowledge and return edges of the channel being served, so the discard path is exercised while the memory protocol itself stays legal.

// File: rtl/audio_refill_pkg.sv
package audio_refill_pkg;
  typedef enum logic [1:0] {FS_IDLE, FS_REQ, FS_WAIT} fetch_state_e;
endpackage

// File: rtl/refill_fifo.sv
module refill_fifo #(
  parameter int SW    = 16,
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            push,
  input  logic [2*SW-1:0] push_word,
  input  logic            pop,
  output logic            out_valid,
  output logic [SW-1:0]   out_data,
  output logic            has_room
);
  localparam int WDEPTH = DEPTH / 2;
  localparam int PW     = (WDEPTH > 1) ? $clog2(WDEPTH) : 1;
  localparam int CW     = $clog2(WDEPTH + 1);

  logic [2*SW-1:0] mem [WDEPTH];
  logic [PW-1:0]   wptr, rptr;
  logic            half;
  logic [CW-1:0]   words;
  logic            pop_ok;

  assign pop_ok = pop && (words != '0);

  // word storage, no reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (push && !flush) mem[wptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      half  <= 1'b0;
      words <= '0;
    end else begin
      if (push) wptr <= (wptr == PW'(WDEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok) begin
        if (half) begin
          rptr <= (rptr == PW'(WDEPTH - 1)) ? '0 : rptr + 1'b1;
          half <= 1'b0;
        end else begin
          half <= 1'b1;
        end
      end
      words <= words + CW'(push) - CW'(pop_ok && half);
    end
  end

  assign out_valid = (words != '0);
  assign out_data  = half ? mem[rptr][2*SW-1:SW] : mem[rptr][SW-1:0];
  // room for two samples == a free word slot
  assign has_room  = (words < CW'(WDEPTH));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (push && !flush) |-> (words < CW'(WDEPTH)));
  p_empty_pop_ignored_r1: assert property (@(posedge clk) disable iff (rst)
    (pop && !out_valid && !push && !flush) |=> !out_valid);
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid);
endmodule

// File: rtl/refill_ptr.sv
module refill_ptr #(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_base,
  input  logic [LW-1:0] load_len,
  input  logic          advance,
  output logic [AW-1:0] addr,
  output logic          wrapped,
  output logic          active
);
  logic [AW-1:0] base;
  logic [LW-1:0] len;
  logic [LW-1:0] off;
  logic [LW:0]   off_next;

  assign off_next = {1'b0, off} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      base    <= '0;
      len     <= '0;
      off     <= '0;
      wrapped <= 1'b0;
      active  <= 1'b0;
    end else if (load) begin
      base    <= load_base;
      len     <= load_len;
      off     <= '0;
      wrapped <= 1'b0;
      active  <= 1'b1;
    end else if (advance) begin
      if (off_next >= {1'b0, len}) begin
        off     <= '0;
        wrapped <= 1'b1;
      end else begin
        off <= off_next[LW-1:0];
      end
    end
  end

  assign addr = base + AW'(off);

  p_load_restarts_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr == $past(load_base)) && !wrapped && active);
endmodule

// File: rtl/refill_arb.sv
module refill_arb #(
  parameter int N = 8
) (
  input  logic [N-1:0]         req,
  input  logic [$clog2(N)-1:0] last,
  output logic                 any,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = 1; k <= N; k++) begin
      if (!any && req[(int'(last) + k) % N]) begin
        any = 1'b1;
        idx = IW'((int'(last) + k) % N);
      end
    end
  end
endmodule

// File: rtl/audio_refill.sv
module audio_refill
  import audio_refill_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int SW    = 16,
  parameter int DEPTH = 16,
  parameter int AW    = 16,
  parameter int LW    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [$clog2(NCH)-1:0] cfg_ch,
  input  logic [AW-1:0]        cfg_base,
  input  logic [LW-1:0]        cfg_len,
  output logic                 mem_req,
  output logic [AW-1:0]        mem_addr,
  input  logic                 mem_ack,
  input  logic                 mem_rvalid,
  input  logic [2*SW-1:0]      mem_rdata,
  input  logic [NCH-1:0]       smp_pop,
  output logic [NCH-1:0]       smp_valid,
  output logic [NCH*SW-1:0]    smp_data,
  output logic [NCH-1:0]       wrapped
);
  localparam int IW = $clog2(NCH);

  fetch_state_e  st;
  logic [IW-1:0] cur_ch, last_ch, gidx;
  logic          stale, arb_any;
  logic [NCH-1:0] cfg_hit, need, room, active, push, advance;
  logic [AW-1:0] ch_addr [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign cfg_hit[c] = cfg_we && (cfg_ch == IW'(c));
    assign need[c]    = active[c] && room[c];
    assign advance[c] = (st == FS_REQ) && mem_ack && (cur_ch == IW'(c))
                        && !stale && !cfg_hit[c];
    assign push[c]    = (st == FS_WAIT) && mem_rvalid && (cur_ch == IW'(c))
                        && !stale && !cfg_hit[c];

    refill_fifo #(.SW(SW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .flush(cfg_hit[c]),
      .push(push[c]), .push_word(mem_rdata), .pop(smp_pop[c]),
      .out_valid(smp_valid[c]), .out_data(smp_data[c*SW +: SW]),
      .has_room(room[c])
    );

    refill_ptr #(.AW(AW), .LW(LW)) u_ptr (
      .clk(clk), .rst(rst), .load(cfg_hit[c]),
      .load_base(cfg_base), .load_len(cfg_len), .advance(advance[c]),
      .addr(ch_addr[c]), .wrapped(wrapped[c]), .active(active[c])
    );
  end

  refill_arb #(.N(NCH)) u_arb (
    .req(need), .last(last_ch), .any(arb_any), .idx(gidx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= FS_IDLE;
      cur_ch   <= '0;
      last_ch  <= '0;
      stale    <= 1'b0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else begin
      unique case (st)
        FS_IDLE: if (arb_any) begin
          cur_ch   <= gidx;
          last_ch  <= gidx;
          mem_req  <= 1'b1;
          mem_addr <= ch_addr[gidx];
          stale    <= cfg_hit[gidx];
          st       <= FS_REQ;
        end
        FS_REQ: begin
          if (cfg_hit[cur_ch]) stale <= 1'b1;
          if (mem_ack) begin
            mem_req <= 1'b0;
            st      <= FS_WAIT;
          end
        end
        FS_WAIT: begin
          if (cfg_hit[cur_ch]) stale <= 1'b1;
          if (mem_rvalid) begin
            stale <= 1'b0;
            st    <= FS_IDLE;
          end
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

  p_req_held_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  p_quiet_while_waiting_r8: assert property (@(posedge clk) disable iff (rst)
    (st == FS_WAIT) |-> !mem_req);
  p_grant_has_room_r6: assert property (@(posedge clk) disable iff (rst)
    (st == FS_IDLE && arb_any) |-> (room[gidx] && active[gidx]));
  p_single_push_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(push));
  p_idle_before_config_r2: assert property (@(posedge clk) disable iff (rst)
    (active == '0) |=> !mem_req || $past(st != FS_IDLE));
endmodule

// File: tb/audio_refill_bench.sv
module audio_refill_bench;
  localparam int NCH = 8;
  localparam int SW  = 16;
  localparam int AW  = 16;
  localparam int LW  = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst;
  logic            cfg_we;
  logic [2:0]      cfg_ch;
  logic [AW-1:0]   cfg_base;
  logic [LW-1:0]   cfg_len;
  logic            mem_req;
  logic [AW-1:0]   mem_addr;
  logic            mem_ack, mem_rvalid;
  logic [31:0]     mem_rdata;
  logic [NCH-1:0]  smp_pop, smp_valid, wrapped;
  logic [NCH*SW-1:0] smp_data;

  audio_refill u_audio_refill (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_base(cfg_base), .cfg_len(cfg_len), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .smp_pop(smp_pop), .smp_valid(smp_valid),
    .smp_data(smp_data), .wrapped(wrapped)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model
  typedef logic [15:0] sq_t[$];
  sq_t q [NCH];
  int  m_base [NCH];
  int  m_len  [NCH];
  int  m_off  [NCH];
  bit  m_act  [NCH];
  bit  m_wrap [NCH];
  int  m_last, m_phase, m_cur, m_cnt;
  int  m_cur_addr;
  bit  m_stale;
  bit  [NCH-1:0] need_prev, need_now;
  bit  prev_we;
  int  prev_ch;

  function automatic logic [15:0] lo_of(int a);
    return 16'(a * 3 + 1);
  endfunction
  function automatic logic [15:0] hi_of(int a);
    return 16'(a) ^ 16'hC3C3;
  endfunction
  function automatic int rr(int last, bit [NCH-1:0] nd);
    for (int k = 1; k <= NCH; k++) begin
      if (nd[(last + k) % NCH]) return (last + k) % NCH;
    end
    return -1;
  endfunction

  initial begin : watchdog
    repeat (30000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 30000, 10000);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    rst = 1'b1; cfg_we = 0; cfg_ch = 0; cfg_base = 0; cfg_len = 0;
    mem_ack = 0; mem_rvalid = 0; mem_rdata = 0; smp_pop = 0;
    for (int c = 0; c < NCH; c++) begin
      q[c].delete(); m_base[c] = 0; m_len[c] = 0; m_off[c] = 0;
      m_act[c] = 0; m_wrap[c] = 0;
    end
    m_last = 0; m_phase = 0; m_cur = 0; m_cnt = 0; m_cur_addr = 0;
    m_stale = 0; need_prev = '0; prev_we = 0; prev_ch = 0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    for (int cyc = 0; cyc < 9000; cyc++) begin
      int  pop_pct, cfg_pct;
      bit  any_act;
      bit  d_we, d_ack, d_rv;
      int  d_ch, d_base, d_len;
      logic [NCH-1:0] d_pop;
      @(negedge clk);

      // compare outputs with the model state after the last edge
      any_act = 1'b0;
      for (int c = 0; c < NCH; c++) begin
        any_act |= m_act[c];
        chk(smp_valid[c] == (q[c].size() > 0), "R1", "smp_valid",
            smp_valid[c], q[c].size() > 0);
        if (q[c].size() > 0)
          chk(smp_data[c*SW +: SW] == q[c][0], "R5", "smp_data",
              smp_data[c*SW +: SW], q[c][0]);
        chk(wrapped[c] == m_wrap[c], "R4", "wrapped", wrapped[c], m_wrap[c]);
        chk(q[c].size() <= 16, "R6", "queue depth", q[c].size(), 16);
      end
      if (!any_act) chk(!mem_req, "R2", "mem_req before config", mem_req, 0);

      if (m_phase == 0) begin
        if (mem_req) begin
          int exp_ch;
          m_cur = int'(mem_addr[10:8]);
          exp_ch = rr(m_last, need_prev);
          chk(need_prev[m_cur], "R6", "grant to channel with room",
              need_prev, m_cur);
          chk(m_cur == exp_ch, "R7", "round-robin grant", m_cur, exp_ch);
          m_cur_addr = int'(mem_addr);
          m_stale = prev_we && (prev_ch == m_cur);
          m_last  = m_cur;
          m_phase = 1;
          m_cnt   = $urandom_range(0, 3);
        end
      end else if (m_phase == 1) begin
        chk(mem_req && (int'(mem_addr) == m_cur_addr), "R8",
            "request held", mem_addr, m_cur_addr);
      end else begin
        chk(!mem_req, "R8", "no second request", mem_req, 0);
      end

      for (int c = 0; c < NCH; c++)
        need_now[c] = m_act[c] && (q[c].size() <= 14);

      // stimulus for the next edge
      if (cyc < 20)        begin pop_pct = 0;  cfg_pct = 0; end
      else if (cyc < 1500) begin pop_pct = 30; cfg_pct = 0; end
      else if (cyc < 3000) begin pop_pct = 0;  cfg_pct = 0; end
      else if (cyc < 3200) begin pop_pct = 60; cfg_pct = 0; end
      else                 begin pop_pct = 40; cfg_pct = 3; end

      d_ack = 0; d_rv = 0;
      if (m_phase == 1) begin
        if (m_cnt == 0) d_ack = 1; else m_cnt--;
      end else if (m_phase == 2) begin
        if (m_cnt == 0) d_rv = 1; else m_cnt--;
      end

      d_we = 0; d_ch = 0; d_base = 0; d_len = 0;
      if (cyc >= 20 && cyc < 28) begin
        d_we = 1; d_ch = cyc - 20;
        d_base = d_ch * 256 + d_ch * 7;
        d_len  = (d_ch == 0) ? 0 : (d_ch == 1) ? 1 : (d_ch == 7) ? 40 : d_ch + 2;
      end else if (cyc >= 3200) begin
        if (($urandom_range(0, 99) < cfg_pct) ||
            ((d_rv || d_ack || m_phase != 0) && $urandom_range(0, 99) < 4)) begin
          d_we = 1;
          d_ch = (m_phase != 0 && $urandom_range(0, 1) == 1) ?
                 m_cur : int'($urandom_range(0, NCH - 1));
          d_base = d_ch * 256 + int'($urandom_range(0, 150));
          d_len  = int'($urandom_range(0, 40));
        end
      end

      for (int c = 0; c < NCH; c++)
        d_pop[c] = ($urandom_range(0, 99) < pop_pct);
      // occasionally pop an empty queue to show it is ignored (R1)
      if (cyc >= 28 && cyc < 1500 && $urandom_range(0, 9) == 0)
        for (int c = 0; c < NCH; c++) if (q[c].size() == 0) d_pop[c] = 1'b1;

      cfg_we = d_we; cfg_ch = 3'(d_ch); cfg_base = AW'(d_base);
      cfg_len = LW'(d_len);
      mem_ack = d_ack; mem_rvalid = d_rv;
      mem_rdata = d_rv ? {hi_of(m_cur_addr), lo_of(m_cur_addr)} : 32'h0;
      smp_pop = d_pop;

      // model the coming edge
      if (d_we && m_phase != 0 && d_ch == m_cur) m_stale = 1'b1;  // R10
      if (d_ack) begin
        if (!m_stale) begin
          chk(m_cur_addr == m_base[m_cur] + m_off[m_cur], "R3",
              "read address", m_cur_addr, m_base[m_cur] + m_off[m_cur]);
          if (m_off[m_cur] + 1 >= m_len[m_cur]) begin
            m_off[m_cur] = 0; m_wrap[m_cur] = 1'b1;
          end else begin
            m_off[m_cur]++;
          end
        end
        m_phase = 2;
        m_cnt = $urandom_range(0, 3);
      end
      for (int c = 0; c < NCH; c++)
        if (d_pop[c] && q[c].size() > 0) void'(q[c].pop_front());
      if (d_rv) begin
        if (!m_stale) begin
          q[m_cur].push_back(lo_of(m_cur_addr));
          q[m_cur].push_back(hi_of(m_cur_addr));
        end
        m_phase = 0;
        m_stale = 1'b0;
      end
      if (d_we) begin  // R9
        q[d_ch].delete();
        m_base[d_ch] = d_base; m_len[d_ch] = d_len;
        m_off[d_ch] = 0; m_wrap[d_ch] = 1'b0; m_act[d_ch] = 1'b1;
      end
      need_prev = need_now;
      prev_we = d_we;
      prev_ch = d_ch;
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule